// File: doc/BRIEF.md
# Single-Wire Half-Duplex Configuration Port

This block gives a host read and write access to a 64-bit configuration image over a single bidirectional pin. Framing is asynchronous 8N1: a low start bit, eight data bits least significant first, no parity and one high stop bit. The bit time is a fixed number of reference-clock cycles, `BIT_CYC`, which is 512 by default. The port arms only after a power-up hold-off and only while the active-low program input is held low. Once armed, it waits for an entry byte, which places it in access mode. After that it takes write and read commands until program mode is left.

A write command is followed by eight bytes, lowest byte first, and they land in a shadow image. A read command makes the port wait a turnaround interval for the host to release the line. The port then drives the pin and sends the shadow image back, lowest byte first, and releases the pin as soon as the last stop bit has ended. The shadow image models nonvolatile storage. The configuration that the rest of the chip uses is a separate active register, and only an explicit reload copies the shadow image into it. Decoded divider and modulation-depth fields are taken from the active register.

Top module: `cfg_port`

## Requirements
- R1: After reset the active image and all decoded fields are zero, the pin output enable is low and the access-mode indicator is low.
- R2: No received byte has any effect while `prog_ni` is high, or before `ARM_CYC` clock cycles have passed since reset.
- R3: While the port is armed and outside access mode, the byte 0xFD sets `acc_o`; every other byte is ignored.
- R4: The receiver takes 8N1 frames, LSB first, with a nominal bit time of `BIT_CYC` cycles. It samples each bit a quarter bit after its nominal start, so host bit times from 0.93 to 1.025 of nominal are accepted. A frame whose stop bit reads low is discarded.
- R5: In access mode, command 0x00 stores the next eight good bytes into the shadow image: byte k goes to bits 8k+7..8k, with k starting at 0.
- R6: In access mode, command 0x40 leaves the pin undriven for `TURN_CYC` cycles after the command is stored. The port then drives the pin and sends shadow bytes 0 through 7 as 8N1 frames, with the output enable held high between the frames.
- R7: The output enable falls within two cycles after the stop bit of byte 7 ends, and the port returns to waiting for a command.
- R8: The active image `cfg_o` changes only on a cycle in which `reload_i` is high, and it then takes the shadow image.
- R9: A byte is stored at rising edge BIT_CYC/4 + 9*BIT_CYC + 3, where edge 0 is the first edge that samples its start bit low. A reload sampled on that same edge captures the shadow image as it was before the store; a reload one edge later captures the image with the store included.
- R10: The decoded fields are `mdiv_o` = cfg[11:0], `ndiv_o` = cfg[22:12], `kdiv_o` = cfg[29:23], `ldiv_o` = cfg[32:30] and `rate_o` = cfg[44:42].
- R11: In access mode, a command byte other than 0x00 or 0x40 is ignored, and the port stays in access mode.
- R12: Raising `prog_ni` leaves access mode, drops the output enable within two cycles, and aborts any transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_ni | input | 1 | Program mode, active low |
| line_i | input | 1 | Level sensed on the shared serial pin |
| line_o | output | 1 | Level driven onto the serial pin |
| line_oe_o | output | 1 | Output enable for the serial pin |
| reload_i | input | 1 | Copies the shadow image into the active image |
| acc_o | output | 1 | High while the port is in access mode |
| cfg_o | output | 64 | Active configuration image |
| mdiv_o | output | 12 | Feedback divider field |
| ndiv_o | output | 11 | Reference divider field |
| kdiv_o | output | 7 | Output divider field |
| ldiv_o | output | 3 | Modulation period field |
| rate_o | output | 3 | Modulation depth field |

## Verification
Two functions can act on the same cycle: the store of the last byte of a write, and a reload from the host side. Both touch the shadow image. The bench works out the store edge from the R9 latency, starting at the negedge on which it launches the start bit. It raises `reload_i` for exactly that edge in one write and for the following edge in another. It then compares `cfg_o` with a spliced image (old top byte, new lower seven bytes) in the first case and with the full new image in the second. The same pass also runs bytes at 0.94 and 1.02 of the nominal bit time and includes one frame with a low stop bit. Both must leave the image that is read back intact.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [2:0] {S_ENTRY, S_CMD, S_WR, S_TURN, S_LOAD, S_SEND} port_st_e;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_e;

  localparam logic [7:0] ENTRY_CODE = 8'hFD;
  localparam logic [7:0] WR_CODE    = 8'h00;
  localparam logic [7:0] RD_CODE    = 8'h40;

  localparam int M_LSB = 0;
  localparam int M_W   = 12;
  localparam int N_LSB = 12;
  localparam int N_W   = 11;
  localparam int K_LSB = 23;
  localparam int K_W   = 7;
  localparam int L_LSB = 30;
  localparam int L_W   = 3;
  localparam int R_LSB = 42;
  localparam int R_W   = 3;
endpackage

// File: rtl/cfgport_rx.sv
module cfgport_rx
  import cfgport_pkg::*;
#(
  parameter int BIT_CYC = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       line_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int CW  = $clog2(BIT_CYC);
  localparam int QTR = BIT_CYC / 4;

  logic [1:0]    sync_q;
  rx_st_e        st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    nb_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  // sample a quarter bit in: keeps the stop bit inside the window over the full rate tolerance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= R_IDLE;
      cnt_q   <= '0;
      nb_q    <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        st_q <= R_IDLE;
      end else begin
        case (st_q)
          R_IDLE: begin
            cnt_q <= '0;
            if (!sync_q[1]) st_q <= R_START;
          end
          R_START: begin
            if (cnt_q == CW'(QTR - 1)) begin
              cnt_q <= '0;
              nb_q  <= '0;
              st_q  <= sync_q[1] ? R_IDLE : R_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          R_DATA: begin
            if (cnt_q == CW'(BIT_CYC - 1)) begin
              cnt_q <= '0;
              sh_q  <= {sync_q[1], sh_q[7:1]};
              nb_q  <= nb_q + 1'b1;
              if (nb_q == 3'd7) st_q <= R_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          R_STOP: begin
            if (cnt_q == CW'(BIT_CYC - 1)) begin
              cnt_q <= '0;
              st_q  <= R_IDLE;
              if (sync_q[1]) begin
                valid_o <= 1'b1;
                data_o  <= sh_q;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= R_IDLE;
        endcase
      end
    end
  end

  a_r4_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sync_q[1]));
endmodule

// File: rtl/cfgport_tx.sv
module cfgport_tx #(
  parameter int BIT_CYC = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       line_o
);
  localparam int CW = $clog2(BIT_CYC);

  logic [9:0]    sh_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      nb_q   <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        busy_o <= 1'b0;
        sh_q   <= '1;
      end else if (start_i && !busy_o) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        cnt_q  <= '0;
        nb_q   <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (cnt_q == CW'(BIT_CYC - 1)) begin
          cnt_q <= '0;
          sh_q  <= {1'b1, sh_q[9:1]};
          nb_q  <= nb_q + 1'b1;
          if (nb_q == 4'd9) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = busy_o ? sh_q[0] : 1'b1;

  a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !clr_i) |=> (busy_o && !line_o));
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfgport_pkg::*;
#(
  parameter int BIT_CYC  = 512,
  parameter int ARM_CYC  = 1500000,
  parameter int TURN_CYC = 1024,
  parameter int CFG_W    = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_ni,
  input  logic             line_i,
  output logic             line_o,
  output logic             line_oe_o,
  input  logic             reload_i,
  output logic             acc_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic [M_W-1:0]   mdiv_o,
  output logic [N_W-1:0]   ndiv_o,
  output logic [K_W-1:0]   kdiv_o,
  output logic [L_W-1:0]   ldiv_o,
  output logic [R_W-1:0]   rate_o
);
  localparam int BYTES = CFG_W / 8;
  localparam int IDX_W = $clog2(BYTES);
  localparam int AW    = $clog2(ARM_CYC + 1);
  localparam int TW    = $clog2(TURN_CYC);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

  port_st_e         st_q;
  logic [AW-1:0]    arm_q;
  logic [TW-1:0]    turn_q;
  logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
  logic [CFG_W-1:0] shadow_q, active_q;
  logic             armed, halt;
  logic             rx_en, rx_valid;
  logic [7:0]       rx_data;
  logic             tx_start, tx_busy, tx_done, tx_line;

  assign armed = (arm_q == AW'(ARM_CYC));
  assign halt  = prog_ni || !armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= '0;
    else if (!armed) arm_q <= arm_q + 1'b1;
  end

  assign rx_en = !halt && (st_q == S_ENTRY || st_q == S_CMD || st_q == S_WR);

  cfgport_rx #(.BIT_CYC(BIT_CYC)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en),
    .line_i (line_i),
    .valid_o(rx_valid),
    .data_o (rx_data)
  );

  assign tx_start = (st_q == S_LOAD);

  cfgport_tx #(.BIT_CYC(BIT_CYC)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (halt),
    .start_i(tx_start),
    .data_i (shadow_q[{rd_idx_q, 3'b000} +: 8]),
    .busy_o (tx_busy),
    .done_o (tx_done),
    .line_o (tx_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_ENTRY;
      turn_q   <= '0;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      shadow_q <= '0;
    end else if (halt) begin
      st_q     <= S_ENTRY;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else begin
      case (st_q)
        S_ENTRY: if (rx_valid && rx_data == ENTRY_CODE) st_q <= S_CMD;
        S_CMD: begin
          if (rx_valid && rx_data == WR_CODE) begin
            st_q     <= S_WR;
            wr_idx_q <= '0;
          end else if (rx_valid && rx_data == RD_CODE) begin
            st_q     <= S_TURN;
            turn_q   <= '0;
            rd_idx_q <= '0;
          end
        end
        S_WR: begin
          if (rx_valid) begin
            shadow_q[{wr_idx_q, 3'b000} +: 8] <= rx_data;
            wr_idx_q <= wr_idx_q + 1'b1;
            if (wr_idx_q == LAST) st_q <= S_CMD;
          end
        end
        S_TURN: begin
          if (turn_q == TW'(TURN_CYC - 1)) st_q <= S_LOAD;
          else turn_q <= turn_q + 1'b1;
        end
        S_LOAD: st_q <= S_SEND;
        S_SEND: begin
          if (tx_done) begin
            if (rd_idx_q == LAST) st_q <= S_CMD;
            else begin
              rd_idx_q <= rd_idx_q + 1'b1;
              st_q     <= S_LOAD;
            end
          end
        end
        default: st_q <= S_ENTRY;
      endcase
    end
  end

  // reload sees the shadow value from before this edge: a coinciding store is not included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= '0;
    else if (reload_i) active_q <= shadow_q;
  end

  assign line_oe_o = (st_q == S_LOAD) || (st_q == S_SEND);
  assign line_o    = tx_line;
  assign acc_o     = (st_q != S_ENTRY);
  assign cfg_o     = active_q;
  assign mdiv_o    = active_q[M_LSB +: M_W];
  assign ndiv_o    = active_q[N_LSB +: N_W];
  assign kdiv_o    = active_q[K_LSB +: K_W];
  assign ldiv_o    = active_q[L_LSB +: L_W];
  assign rate_o    = active_q[R_LSB +: R_W];

  a_r2_prog_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_ni |=> !acc_o);
  a_r6_drive_after_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_oe_o) |-> ($past(st_q) == S_TURN || $past(st_q) == S_SEND));
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SEND && tx_done && rd_idx_q == LAST) |=> !line_oe_o);
  a_r8_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> $stable(cfg_o));
endmodule

// File: tb/sim_cfg_port.sv
module sim_cfg_port;
  localparam int BIT  = 96;
  localparam int ARM  = 3000;
  localparam int TURN = 150;
  localparam int LAT  = BIT / 4 + 9 * BIT + 3;

  logic clk = 1'b0, rst_ni = 1'b0, prog_ni = 1'b0, reload_i = 1'b0;
  logic host_en = 1'b1, host_val = 1'b1;
  logic line, line_o, line_oe_o, acc_o;
  logic [63:0] cfg_o;
  logic [11:0] mdiv_o;
  logic [10:0] ndiv_o;
  logic [6:0]  kdiv_o;
  logic [2:0]  ldiv_o, rate_o;

  assign line = line_oe_o ? line_o : (host_en ? host_val : 1'b1);

  cfg_port #(.BIT_CYC(BIT), .ARM_CYC(ARM), .TURN_CYC(TURN), .CFG_W(64)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .prog_ni(prog_ni), .line_i(line),
    .line_o(line_o), .line_oe_o(line_oe_o), .reload_i(reload_i), .acc_o(acc_o),
    .cfg_o(cfg_o), .mdiv_o(mdiv_o), .ndiv_o(ndiv_o), .kdiv_o(kdiv_o),
    .ldiv_o(ldiv_o), .rate_o(rate_o)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit clash = 1'b0;

  always @(negedge clk) if (line_oe_o && host_en) clash = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      bad++;
      $display("FAIL watchdog all act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // starts at a negedge; rl_at = negedge index within the frame on which reload is raised
  task automatic send_byte(input logic [7:0] d, input int per, input bit stop_v, input int rl_at);
    logic [9:0] fr;
    fr = {stop_v, d, 1'b0};
    host_en = 1'b1;
    for (int c = 0; c < 10 * per; c++) begin
      host_val = fr[c / per];
      reload_i = (c == rl_at);
      @(negedge clk);
    end
    reload_i = 1'b0;
    host_val = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic pulse_reload();
    reload_i = 1'b1;
    @(negedge clk);
    reload_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_image(input logic [63:0] img, input bit vary, input int rl_d);
    send_byte(8'h00, BIT, 1'b1, -1);
    for (int k = 0; k < 8; k++) begin
      int per;
      per = (vary && k != 7) ? ((k % 2 == 1) ? 98 : 90) : BIT;
      if (vary && k == 3) send_byte(8'hA5, 90, 1'b0, -1);
      send_byte(img[8*k +: 8], per, 1'b1, (k == 7 && rl_d >= 0) ? LAT + rl_d : -1);
    end
  endtask

  task automatic rd_image(output logic [63:0] got);
    bit frame_ok, oe_ok;
    frame_ok = 1'b1;
    oe_ok    = 1'b1;
    got      = '0;
    send_byte(8'h40, BIT, 1'b1, -1);
    host_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      int w;
      w = 0;
      while (line !== 1'b0 && w < 5000) begin
        @(negedge clk);
        w++;
      end
      repeat (BIT / 2) @(negedge clk);
      if (line !== 1'b0) frame_ok = 1'b0;
      for (int b = 0; b < 8; b++) begin
        repeat (BIT) @(negedge clk);
        got[8*k + b] = line;
      end
      repeat (BIT) @(negedge clk);
      if (line !== 1'b1) frame_ok = 1'b0;
      if (line_oe_o !== 1'b1) oe_ok = 1'b0;
    end
    chk(frame_ok && oe_ok, "R6 read frames driven", {62'd0, frame_ok, oe_ok}, 64'd3);
    repeat (BIT / 2 + 3) @(negedge clk);
    chk(line_oe_o == 1'b0 && acc_o == 1'b1, "R7 release after last stop",
        {62'd0, line_oe_o, acc_o}, 64'd1);
    host_en  = 1'b1;
    host_val = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    logic [63:0] a, b, c, d, got;
    void'($urandom(32'd2024));
    a = {$urandom, $urandom};
    b = {$urandom, $urandom};
    c = {$urandom, $urandom};
    d = 64'h8000_0000_0000_0001;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cfg_o == '0, "R1 active image zero", cfg_o, '0);
    chk({mdiv_o, ndiv_o, kdiv_o, ldiv_o, rate_o} == '0, "R1 fields zero",
        {28'd0, mdiv_o, ndiv_o, kdiv_o, ldiv_o, rate_o}, '0);
    chk(line_oe_o == 1'b0 && acc_o == 1'b0, "R1 pin released, no access",
        {62'd0, line_oe_o, acc_o}, '0);

    send_byte(8'hFD, BIT, 1'b1, -1);
    chk(acc_o == 1'b0, "R2 entry before hold-off", {63'd0, acc_o}, 64'd0);
    repeat (2500) @(negedge clk);
    prog_ni = 1'b1;
    repeat (5) @(negedge clk);
    send_byte(8'hFD, BIT, 1'b1, -1);
    chk(acc_o == 1'b0, "R2 entry with program input high", {63'd0, acc_o}, 64'd0);
    prog_ni = 1'b0;
    repeat (5) @(negedge clk);

    send_byte(8'h55, BIT, 1'b1, -1);
    chk(acc_o == 1'b0, "R3 wrong entry byte ignored", {63'd0, acc_o}, 64'd0);
    send_byte(8'hFD, BIT, 1'b1, -1);
    chk(acc_o == 1'b1, "R3 entry byte accepted", {63'd0, acc_o}, 64'd1);

    send_byte(8'h13, BIT, 1'b1, -1);
    chk(acc_o == 1'b1, "R11 unknown command keeps access", {63'd0, acc_o}, 64'd1);

    wr_image(a, 1'b0, -1);
    chk(cfg_o == '0, "R8 active unchanged before reload", cfg_o, '0);
    pulse_reload();
    chk(cfg_o == a, "R5 R8 write then reload", cfg_o, a);
    chk({mdiv_o, ndiv_o, kdiv_o, ldiv_o, rate_o} ==
        {a[11:0], a[22:12], a[29:23], a[32:30], a[44:42]}, "R10 field decode",
        {28'd0, mdiv_o, ndiv_o, kdiv_o, ldiv_o, rate_o},
        {28'd0, a[11:0], a[22:12], a[29:23], a[32:30], a[44:42]});

    rd_image(got);
    chk(got == a, "R6 read back image", got, a);

    wr_image(b, 1'b1, 0);
    chk(cfg_o == {a[63:56], b[55:0]}, "R9 reload on store edge takes old byte",
        cfg_o, {a[63:56], b[55:0]});
    pulse_reload();
    chk(cfg_o == b, "R4 rate tolerance and bad stop discarded", cfg_o, b);

    wr_image(c, 1'b0, 1);
    chk(cfg_o == c, "R9 reload one edge after store takes new byte", cfg_o, c);
    rd_image(got);
    chk(got == c, "R5 R6 read after write", got, c);

    wr_image(d, 1'b0, -1);
    chk(cfg_o == c, "R8 write alone leaves active image", cfg_o, c);
    rd_image(got);
    chk(got == d, "R5 directed corner image", got, d);
    chk(!clash, "R6 no drive while host drives", {63'd0, clash}, 64'd0);

    send_byte(8'h40, BIT, 1'b1, -1);
    host_en = 1'b0;
    for (int w = 0; w < 2000 && !line_oe_o; w++) @(negedge clk);
    repeat (200) @(negedge clk);
    prog_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_oe_o == 1'b0 && acc_o == 1'b0, "R12 program exit aborts read",
        {62'd0, line_oe_o, acc_o}, '0);
    host_en = 1'b1;
    send_byte(8'h40, BIT, 1'b1, -1);
    host_en = 1'b0;
    repeat (300) @(negedge clk);
    chk(line_oe_o == 1'b0, "R12 read command ignored outside program mode",
        {63'd0, line_oe_o}, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule